// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block interprets the write traffic that reaches a word-wide non-volatile memory model. A command is a series of bus writes that carries address/data pairs. The block recognises two-write unlock prefixes and the three-, four- and six-write sequences built on them. These sequences start word program, full erase, main-array erase and boot-region lockout, and they enter or leave identification mode. The block also owns a small synthesizable storage array. It applies the protection rules of the boot region to that array and answers reads, either from the array or from the identification table.

Each operation that takes effect raises a one-cycle strobe. A level output shows the identification mode and another shows the lockout state, for the array and status logic around the block. The storage array models each region with `2**MEM_AW` words, so the default configuration stays small. Analog programming pulses, timing to completion and supply sensing are not modelled.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `id_mode`, `boot_locked` and all four strobes are 0. Every word reads FFFFh.
- R2: Every command opens with a write of AAh to 5555h, then a write of 55h to 2AAAh. In every command cycle only `wr_data[7:0]` is compared, so bits 15:8 may hold any value.
- R3: After the prefix, A0h written to 5555h arms program. The next write, to any address, ANDs its full 16-bit data into the addressed word, and `prog_pulse` is high for the one cycle after that write.
- R4: While `boot_locked` is 1, a program aimed at the boot region (addresses 0000h to 1FFFh) leaves the word unchanged and raises no `prog_pulse`.
- R5: The six-write sequence prefix, 80h@5555h, prefix, 10h@5555h is a chip erase. It sets every word to FFFFh when unlocked, and only the main-region words when locked. `chip_erase_pulse` follows for one cycle.
- R6: The same six-write form ending in 30h is a main-array erase. It sets every main-region word (address above 1FFFh) to FFFFh, leaves the boot region unchanged, and pulses `main_erase_pulse`.
- R7: The same six-write form ending in 40h sets `boot_locked` and pulses `lock_pulse`. Once set, `boot_locked` stays set until reset.
- R8: The prefix followed by 90h@5555h sets `id_mode`. While it is set, reads return `MFR_ID` at 0000h, `DEV_ID` at 0001h, the lockout state on bit 0 at 0002h (1 means locked), and 0000h elsewhere.
- R9: `id_mode` clears either on the prefix followed by F0h@5555h, or on a single write of F0h to any address when no sequence is in progress.
- R10: A write that does not match the expected address and data returns the decoder to idle with no side effect. The mismatching write does not itself begin a new sequence.
- R11: Outside identification mode, `rd_data` is the stored word. Word index = {address > 1FFFh, address[MEM_AW-1:0]}, so higher in-region bits alias. A write at idle that does not open a sequence changes no word.
- R12: At most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; also clears the lockout |
| wr_en | input | 1 | One bus write per cycle while high |
| wr_addr | input | 16 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 16 | Read address |
| rd_data | output | 16 | Read data, array or identification table |
| id_mode | output | 1 | Identification mode active |
| boot_locked | output | 1 | Boot region protected |
| prog_pulse | output | 1 | A word program took effect |
| chip_erase_pulse | output | 1 | Chip erase took effect |
| main_erase_pulse | output | 1 | Main-array erase took effect |
| lock_pulse | output | 1 | Lockout enabled |

## Verification
The assertions assume that `wr_en` is a clean level, sampled once per rising edge, and that the address and data are stable whenever `wr_en` is high. They also assume that reset is the only way the lockout clears. The bench drives every input at the falling edge and separates writes with idle cycles, which keeps it inside those assumptions. It sweeps every modelled word of both regions through program, erase and locked-program cases. Its expected contents come from a shadow array built from the stated rules.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int          MEM_AW   = 5,
  parameter logic [15:0] BOOT_END = 16'h1FFF,
  parameter logic [15:0] MFR_ID   = 16'h00C5,
  parameter logic [15:0] DEV_ID   = 16'h00A7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_addr,
  input  logic [15:0] wr_data,
  input  logic [15:0] rd_addr,
  output logic [15:0] rd_data,
  output logic        id_mode,
  output logic        boot_locked,
  output logic        prog_pulse,
  output logic        chip_erase_pulse,
  output logic        main_erase_pulse,
  output logic        lock_pulse
);
  localparam int HALF  = 2 ** MEM_AW;
  localparam int DEPTH = 2 * HALF;
  localparam logic [15:0] KEY_A = 16'h5555;
  localparam logic [15:0] KEY_B = 16'h2AAA;

  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_PROG, S_E3, S_E4, S_E5} st_t;

  st_t         state;
  logic [15:0] mem [DEPTH];

  function automatic logic [MEM_AW:0] to_idx(input logic [15:0] a);
    return {a > BOOT_END, a[MEM_AW-1:0]};
  endfunction

  wire [7:0]        cd      = wr_data[7:0];
  wire              at_a    = wr_addr == KEY_A;
  wire              at_b    = wr_addr == KEY_B;
  wire              wr_boot = wr_addr <= BOOT_END;
  wire [MEM_AW:0]   wr_idx  = to_idx(wr_addr);
  wire [MEM_AW:0]   rd_idx  = to_idx(rd_addr);

  wire last_six = wr_en && state == S_E5 && at_a;
  wire do_prog  = wr_en && state == S_PROG && !(wr_boot && boot_locked);
  wire do_chip  = last_six && cd == 8'h10;
  wire do_main  = last_six && cd == 8'h30;
  wire do_lock  = last_six && cd == 8'h40;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      id_mode <= 1'b0;
    end else if (wr_en) begin
      state <= S_IDLE;
      case (state)
        S_IDLE: begin
          if (at_a && cd == 8'hAA) state <= S_U1;
          else if (cd == 8'hF0)    id_mode <= 1'b0;
        end
        S_U1: if (at_b && cd == 8'h55) state <= S_U2;
        S_U2: if (at_a) begin
          case (cd)
            8'hA0:   state <= S_PROG;
            8'h80:   state <= S_E3;
            8'h90:   id_mode <= 1'b1;
            8'hF0:   id_mode <= 1'b0;
            default: ;
          endcase
        end
        S_E3: if (at_a && cd == 8'hAA) state <= S_E4;
        S_E4: if (at_b && cd == 8'h55) state <= S_E5;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_locked      <= 1'b0;
      prog_pulse       <= 1'b0;
      chip_erase_pulse <= 1'b0;
      main_erase_pulse <= 1'b0;
      lock_pulse       <= 1'b0;
    end else begin
      if (do_lock) boot_locked <= 1'b1;
      prog_pulse       <= do_prog;
      chip_erase_pulse <= do_chip;
      main_erase_pulse <= do_main;
      lock_pulse       <= do_lock;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 16'hFFFF;
    end else begin
      if (do_prog) mem[wr_idx] <= mem[wr_idx] & wr_data;
      for (int i = 0; i < DEPTH; i++)
        if ((do_chip && (i >= HALF || !boot_locked)) || (do_main && i >= HALF))
          mem[i] <= 16'hFFFF;
    end
  end

  always_comb begin
    if (!id_mode)                rd_data = mem[rd_idx];
    else if (rd_addr == 16'h0000) rd_data = MFR_ID;
    else if (rd_addr == 16'h0001) rd_data = DEV_ID;
    else if (rd_addr == 16'h0002) rd_data = {15'b0, boot_locked};
    else                          rd_data = 16'h0000;
  end

  // R12
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_pulse, chip_erase_pulse, main_erase_pulse, lock_pulse}));

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(boot_locked) |-> boot_locked);

  // R3
  prog_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_pulse |-> mem[$past(wr_idx)] == ($past(mem[wr_idx]) & $past(wr_data)));

  // R4
  boot_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && state == S_PROG && wr_boot && boot_locked)
      |=> (!prog_pulse && mem[$past(wr_idx)] == $past(mem[wr_idx])));

  // R6
  main_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    main_erase_pulse |-> (mem[0] == $past(mem[0]) && mem[HALF] == 16'hFFFF));

  // R5
  chip_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_erase_pulse && !boot_locked) |-> (mem[0] == 16'hFFFF && mem[DEPTH-1] == 16'hFFFF));

  // R8
  id_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_mode) |-> $past(wr_en && state == S_U2 && cd == 8'h90));

  // R9
  id_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(id_mode) |-> $past(wr_en && cd == 8'hF0));
endmodule

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
  localparam int CLK_NS = 10;
  localparam int AW     = 5;
  localparam int HALF   = 2 ** AW;
  localparam logic [15:0] MFR = 16'h00C5;
  localparam logic [15:0] DEV = 16'h00A7;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [15:0] wr_addr = 0, wr_data = 0, rd_addr = 0;
  logic [15:0] rd_data;
  logic id_mode, boot_locked, prog_pulse, chip_erase_pulse, main_erase_pulse, lock_pulse;

  int checks = 0, failures = 0;
  logic [15:0] shadow [2*HALF];
  logic [3:0]  pv;
  logic        done = 0;

  always #(CLK_NS/2) clk = ~clk;

  flash_cmd_decoder #(.MEM_AW(AW)) i_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .id_mode(id_mode), .boot_locked(boot_locked),
    .prog_pulse(prog_pulse), .chip_erase_pulse(chip_erase_pulse),
    .main_erase_pulse(main_erase_pulse), .lock_pulse(lock_pulse));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] baddr(input int i); return 16'(i); endfunction
  function automatic logic [15:0] maddr(input int i); return 16'h2000 + 16'(i); endfunction

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    pv = {prog_pulse, chip_erase_pulse, main_erase_pulse, lock_pulse};
    chk("R12", 16'(($countones(pv) <= 1)), 16'd1);
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic prefix(input logic [7:0] hi);
    wr(16'h5555, {hi, 8'hAA});
    wr(16'h2AAA, {hi, 8'h55});
  endtask

  task automatic six(input logic [7:0] code);
    prefix(8'h00); wr(16'h5555, 16'h0080);
    prefix(8'hE7); wr(16'h5555, {8'h5A, code});
  endtask

  task automatic prog(input logic [15:0] a, input logic [15:0] d, input logic [7:0] hi);
    prefix(hi); wr(16'h5555, {hi, 8'hA0}); wr(a, d);
  endtask

  task automatic sweep(input string req);
    logic [15:0] v;
    for (int i = 0; i < HALF; i++) begin
      rd(baddr(i), v); chk(req, v, shadow[i]);
      rd(maddr(i), v); chk(req, v, shadow[HALF+i]);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1;
    for (int i = 0; i < 2*HALF; i++) shadow[i] = 16'hFFFF;
  endtask

  initial begin
    logic [15:0] v, d;
    do_reset();
    // R1
    chk("R1", {12'b0, id_mode, boot_locked, prog_pulse, chip_erase_pulse}, 16'h0);
    chk("R1", {14'b0, main_erase_pulse, lock_pulse}, 16'h0);
    sweep("R1");

    // R2 R3: program every word, upper command bits set
    for (int i = 0; i < 2*HALF; i++) begin
      d = 16'hFFFF ^ (16'h1 << (i % 16)) ^ (16'(i) << 8);
      prog(i < HALF ? baddr(i) : maddr(i-HALF), d, 8'(i * 7 + 1));
      chk("R3 prog_pulse", {15'b0, pv[3]}, 16'h1);
      shadow[i] = shadow[i] & d;
    end
    sweep("R2");
    for (int i = 0; i < 2*HALF; i += 3) begin
      d = 16'h0F0F ^ 16'(i * 37);
      prog(i < HALF ? baddr(i) : maddr(i-HALF), d, 8'h00);
      shadow[i] = shadow[i] & d;
    end
    sweep("R3");

    // R11: aliasing and idle writes
    prog(16'hA004, 16'h00FF, 8'h00); shadow[HALF+4] &= 16'h00FF;
    rd(maddr(4), v); chk("R11 alias", v, shadow[HALF+4]);
    wr(16'h0005, 16'h0000); wr(16'h2005, 16'h0000);
    rd(baddr(5), v); chk("R11 idle write", v, shadow[5]);
    rd(maddr(5), v); chk("R11 idle write", v, shadow[HALF+5]);

    // R10: mismatches
    wr(16'h5555, 16'h00AA); wr(16'h1234, 16'h0055); wr(16'h5555, 16'h00A0); wr(baddr(6), 16'h0000);
    chk("R10 no pulse", {12'b0, pv}, 16'h0);
    rd(baddr(6), v); chk("R10", v, shadow[6]);
    prefix(8'h00); wr(16'h5554, 16'h00A0); wr(baddr(7), 16'h0000);
    rd(baddr(7), v); chk("R10", v, shadow[7]);
    prefix(8'h00); wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h00A0);
    wr(baddr(8), 16'h0000);
    rd(baddr(8), v); chk("R10 no restart", v, shadow[8]);
    prefix(8'h00); wr(16'h5555, 16'h0080); prefix(8'h00); wr(16'h5555, 16'h0020);
    chk("R10 bad code", {12'b0, pv}, 16'h0);
    sweep("R10");

    // R6
    six(8'h30);
    chk("R6 pulse", {12'b0, pv}, 16'h2);
    for (int i = HALF; i < 2*HALF; i++) shadow[i] = 16'hFFFF;
    sweep("R6");

    // R5 unlocked
    for (int i = 0; i < HALF; i++) begin
      prog(maddr(i), 16'h1234 ^ 16'(i), 8'h00); shadow[HALF+i] &= 16'h1234 ^ 16'(i);
    end
    six(8'h10);
    chk("R5 pulse", {12'b0, pv}, 16'h4);
    for (int i = 0; i < 2*HALF; i++) shadow[i] = 16'hFFFF;
    sweep("R5");

    // R8 before lock
    prefix(8'h00); wr(16'h5555, 16'h0090);
    chk("R8 id_mode", {15'b0, id_mode}, 16'h1);
    rd(16'h0002, v); chk("R8 lock bit", v, 16'h0000);
    rd(16'h0000, v); chk("R8 mfr", v, MFR);
    rd(16'h0001, v); chk("R8 dev", v, DEV);
    rd(16'h0003, v); chk("R8 other", v, 16'h0000);
    // R9 single write exit
    wr(16'h1234, 16'h77F0);
    chk("R9 single exit", {15'b0, id_mode}, 16'h0);
    rd(16'h0000, v); chk("R9 array back", v, shadow[0]);

    // R7 lock, then R4
    for (int i = 0; i < HALF; i++) begin
      prog(baddr(i), 16'hC3C3 ^ 16'(i), 8'h00); shadow[i] &= 16'hC3C3 ^ 16'(i);
    end
    six(8'h40);
    chk("R7 pulse", {12'b0, pv}, 16'h1);
    chk("R7 locked", {15'b0, boot_locked}, 16'h1);
    for (int i = 0; i < HALF; i++) begin
      prog(baddr(i), 16'h0000, 8'h00);
      chk("R4 no pulse", {15'b0, pv[3]}, 16'h0);
    end
    prog(maddr(2), 16'h00F0, 8'h00); shadow[HALF+2] &= 16'h00F0;
    chk("R4 main still programs", {15'b0, pv[3]}, 16'h1);
    sweep("R4");

    // R5 locked
    six(8'h10);
    chk("R5 locked pulse", {12'b0, pv}, 16'h4);
    for (int i = HALF; i < 2*HALF; i++) shadow[i] = 16'hFFFF;
    sweep("R5");
    six(8'h30);
    chk("R7 still locked", {15'b0, boot_locked}, 16'h1);

    // R8 after lock, R9 sequence exit
    prefix(8'h00); wr(16'h5555, 16'h0090);
    rd(16'h0002, v); chk("R8 lock bit", v, 16'h0001);
    prefix(8'h00); wr(16'h5555, 16'h00F0);
    chk("R9 seq exit", {15'b0, id_mode}, 16'h0);

    // R7 cleared only by reset
    do_reset();
    chk("R7 reset clears", {15'b0, boot_locked}, 16'h0);
    sweep("R1");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule